// File: doc/BRIEF.md
# Parallel Bus Master Cycle Engine

This block runs byte-wide read and write cycles on an external parallel bus for a host that works through a single data register. A host write request hands over a data word and starts a write; a host read request starts a read whose result is later available on the read-data output. Each byte cycle has three timed parts. The setup part drives select, address and data with the strobe off. The strobe part asserts the strobe. The hold part keeps address and data valid after the strobe. Each length is set in whole clock cycles. A strobe setting of zero collapses the byte into a single cycle.

Two strobe styles are offered: separate read and write strobes, or a direction line with a common enable strobe. In wide mode one host access produces two back-to-back byte cycles, low byte first. Between byte cycles the bus address can hold, count up or count down. A busy flag covers the whole access, and a one-cycle interrupt pulse can mark its end. The host preloads the address while the engine is idle.

Top module: `parbus_master`

## Requirements
- R1: After a synchronous active-low reset, busy, irq, bus_cs, every strobe, bus_be and bus_doe are 0, and host_rdata and bus_addr are 0.
- R2: With cfg_strobe nonzero, each byte cycle starts with cfg_setup+1 cycles (0 gives 1, 3 gives 4) in which bus_cs=1, address and data are valid, and no strobe is active.
- R3: With cfg_strobe = N > 0, the strobe is active for N+1 consecutive cycles (N up to 15).
- R4: After the strobe, a hold part of cfg_hold+1 cycles keeps bus_cs, address and data valid with the strobe off.
- R5: With cfg_strobe = 0, each byte cycle takes exactly one clock with the strobe active, and cfg_setup and cfg_hold have no effect.
- R6: With cfg_dir_en = 0, bus_rd (reads) or bus_wr (writes) is the strobe, and bus_dir and bus_en stay 0.
- R7: With cfg_dir_en = 1, bus_dir is 1 for the whole of a read byte cycle and 0 for a write, bus_en is the strobe, and bus_rd and bus_wr stay 0.
- R8: With cfg_wide = 1, one access makes two byte cycles back to back. The first carries bits 7:0 with bus_be = 0. The second carries bits 15:8 with bus_be = 1. The address update takes effect between them.
- R9: After every byte cycle the address follows cfg_step: 01 adds 1, 10 subtracts 1, 00 and 11 hold. It wraps modulo 2^AW.
- R10: busy is 1 from the cycle after the request is accepted until the last byte cycle ends, and bus_doe is 1 only during write byte cycles. bus_dout is 0 when bus_doe is 0.
- R11: With cfg_irq = 01, irq is high for exactly the one cycle after the access ends. With any other value, irq stays 0.
- R12: A host request made while busy is 1 is ignored. It does not change the running access, and no further access follows.
- R13: Read data is sampled from bus_din at the end of the last strobe cycle of each byte. host_rdata holds it until the next read: wide gives {high, low}, narrow gives {8'h00, low}.
- R14: addr_ld with addr_val loads the bus address while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_setup | input | 2 | Setup length minus one |
| cfg_strobe | input | 4 | Extra strobe cycles; 0 selects single-cycle bytes |
| cfg_hold | input | 2 | Hold length minus one |
| cfg_dir_en | input | 1 | 1: direction plus enable, 0: separate read/write strobes |
| cfg_wide | input | 1 | 1: 16-bit access as two byte cycles |
| cfg_step | input | 2 | Address update: 01 up, 10 down, else hold |
| cfg_irq | input | 2 | 01 enables the end-of-access pulse |
| host_wr | input | 1 | Start a write access (wins over host_rd) |
| host_rd | input | 1 | Start a read access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Last read result |
| addr_ld | input | 1 | Load bus address (idle only) |
| addr_val | input | 14 | Address to load |
| busy | output | 1 | Access in progress |
| irq | output | 1 | End-of-access pulse |
| bus_cs | output | 1 | Chip select |
| bus_rd | output | 1 | Read strobe (separate style) |
| bus_wr | output | 1 | Write strobe (separate style) |
| bus_dir | output | 1 | Direction, 1 = read (enable style) |
| bus_en | output | 1 | Enable strobe (enable style) |
| bus_be | output | 1 | High-byte enable |
| bus_addr | output | 14 | Bus address |
| bus_dout | output | 8 | Write data byte |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 8 | Read data byte |

## Verification
On every cycle, the assertions check that the two strobe styles never mix, that every strobe and bus_be sit inside bus_cs, and that a single-cycle byte only happens with a zero strobe setting. They also check that a request made while busy leaves the latched write data alone, that the address moves by one in the programmed direction, and that irq is a lone pulse after busy. The exact lengths of the setup, strobe and hold parts, the byte order and address of wide accesses, and the point at which read data is sampled are shown only by the bench scenarios. These scenarios compare every output in every cycle against a model of the phase schedule.

// File: rtl/parbus_pkg.sv
// Shared types for the parallel bus master.
// Assumes: one byte cycle is active at a time.
package parbus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_FAST   = 3'd4
    } phase_t;

    localparam logic [1:0] STEP_UP   = 2'b01;
    localparam logic [1:0] STEP_DOWN = 2'b10;
    localparam logic [1:0] IRQ_END   = 2'b01;
endpackage

// File: rtl/parbus_seq.sv
// Phase sequencer: times one byte cycle through setup, strobe and hold,
// or through one single-cycle part when the strobe setting is zero.
// Assumes: start is raised only while idle or in the final cycle of a byte.
module parbus_seq
    import parbus_pkg::*;
#(
    parameter int SHW = 2,
    parameter int WSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [SHW-1:0] cfg_setup,
    input  logic [WSW-1:0] cfg_strobe,
    input  logic [SHW-1:0] cfg_hold,
    output phase_t         phase,
    output logic           last,
    output logic           cap
);
    localparam int CW = (WSW > SHW) ? WSW : SHW;

    phase_t         phase_q;
    logic [CW-1:0]  cnt_q;
    logic [SHW-1:0] s_q, h_q;
    logic [WSW-1:0] w_q;
    logic           idle;
    logic [SHW-1:0] sel_s;
    logic [WSW-1:0] sel_w;

    // Pick live settings for a fresh access, held ones for a second byte.
    always_comb begin
        idle  = (phase_q == PH_IDLE);
        sel_s = idle ? cfg_setup  : s_q;
        sel_w = idle ? cfg_strobe : w_q;
        last  = (phase_q == PH_FAST) || (phase_q == PH_HOLD && cnt_q == '0);
        cap   = (phase_q == PH_FAST) || (phase_q == PH_STROBE && cnt_q == '0);
    end

    // Advance the phase and its down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            s_q     <= '0;
            w_q     <= '0;
            h_q     <= '0;
        end else if (start && (idle || last)) begin
            if (idle) begin
                s_q <= cfg_setup;
                w_q <= cfg_strobe;
                h_q <= cfg_hold;
            end
            if (sel_w == '0) begin
                phase_q <= PH_FAST;
                cnt_q   <= '0;
            end else begin
                phase_q <= PH_SETUP;
                cnt_q   <= CW'(sel_s);
            end
        end else begin
            case (phase_q)
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= CW'(w_q);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                PH_STROBE: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= CW'(h_q);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                PH_HOLD: begin
                    if (cnt_q == '0) phase_q <= PH_IDLE;
                    else cnt_q <= cnt_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;

    // R5: a single-cycle byte only occurs with a zero strobe setting
    a_r5_fast_only_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FAST) |-> (w_q == '0));
    // R3: the timed strobe part only occurs with a nonzero setting
    a_r3_strobe_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE) |-> (w_q != '0));
    // R12: launches happen only when idle or chaining a second byte
    a_r12_start_legal: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (idle || last));
endmodule

// File: rtl/parbus_addr.sv
// Bus address register: host preload and per-byte up/down/hold update.
// Assumes: ld and step are never high together (top gates them by busy).
module parbus_addr
    import parbus_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    input  logic [1:0]    mode,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;

    // Load, then update after each finished byte cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else if (ld) addr_q <= ld_val;
        else if (step) begin
            case (mode)
                STEP_UP:   addr_q <= addr_q + 1'b1;
                STEP_DOWN: addr_q <= addr_q - 1'b1;
                default:   addr_q <= addr_q;
            endcase
        end
    end

    assign addr = addr_q;

    // R9: count up by one
    a_r9_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && mode == STEP_UP) |=> (addr_q == $past(addr_q) + 1'b1));
    // R9: count down by one
    a_r9_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && mode == STEP_DOWN) |=> (addr_q == $past(addr_q) - 1'b1));
    // R9: no movement without a load or a step
    a_r9_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld) |=> $stable(addr_q));
endmodule

// File: rtl/parbus_master.sv
// Parallel bus master top: accepts host read/write requests, runs one or
// two byte cycles through the sequencer, and drives the bus pins.
// Assumes: configuration is sampled when a request is accepted.
module parbus_master
    import parbus_pkg::*;
#(
    parameter int AW  = 14,
    parameter int SHW = 2,
    parameter int WSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SHW-1:0] cfg_setup,
    input  logic [WSW-1:0] cfg_strobe,
    input  logic [SHW-1:0] cfg_hold,
    input  logic           cfg_dir_en,
    input  logic           cfg_wide,
    input  logic [1:0]     cfg_step,
    input  logic [1:0]     cfg_irq,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic [15:0]    host_wdata,
    output logic [15:0]    host_rdata,
    input  logic           addr_ld,
    input  logic [AW-1:0]  addr_val,
    output logic           busy,
    output logic           irq,
    output logic           bus_cs,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic           bus_dir,
    output logic           bus_en,
    output logic           bus_be,
    output logic [AW-1:0]  bus_addr,
    output logic [7:0]     bus_dout,
    output logic           bus_doe,
    input  logic [7:0]     bus_din
);
    phase_t      phase;
    logic        last, cap, accept, chain, start, strobe_on, active;
    logic        op_rd, op_de, op_wide, byte_hi, irq_q;
    logic [1:0]  op_step, op_irq;
    logic [15:0] wdata_q, rdata_q;

    // Request acceptance and second-byte chaining.
    always_comb begin
        active    = (phase != PH_IDLE);
        accept    = (host_wr || host_rd) && !active;
        chain     = last && op_wide && !byte_hi;
        start     = accept || chain;
        strobe_on = (phase == PH_STROBE) || (phase == PH_FAST);
    end

    parbus_seq #(.SHW(SHW), .WSW(WSW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_setup  (cfg_setup),
        .cfg_strobe (cfg_strobe),
        .cfg_hold   (cfg_hold),
        .phase      (phase),
        .last       (last),
        .cap        (cap)
    );

    parbus_addr #(.AW(AW)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (addr_ld && !active),
        .ld_val (addr_val),
        .step   (last),
        .mode   (op_step),
        .addr   (bus_addr)
    );

    // Latch the access description at acceptance; track the byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_rd   <= 1'b0;
            op_de   <= 1'b0;
            op_wide <= 1'b0;
            op_step <= '0;
            op_irq  <= '0;
            wdata_q <= '0;
            byte_hi <= 1'b0;
        end else if (accept) begin
            op_rd   <= !host_wr;
            op_de   <= cfg_dir_en;
            op_wide <= cfg_wide;
            op_step <= cfg_step;
            op_irq  <= cfg_irq;
            wdata_q <= host_wdata;
            byte_hi <= 1'b0;
        end else if (chain) begin
            byte_hi <= 1'b1;
        end
    end

    // Capture read bytes on the final strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (cap && op_rd) begin
            if (byte_hi) rdata_q[15:8] <= bus_din;
            else begin
                rdata_q[7:0] <= bus_din;
                if (!op_wide) rdata_q[15:8] <= 8'h00;
            end
        end
    end

    // End-of-access interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else irq_q <= last && !chain && (op_irq == IRQ_END);
    end

    // Pin decode from phase and latched access.
    always_comb begin
        busy       = active;
        irq        = irq_q;
        host_rdata = rdata_q;
        bus_cs     = active;
        bus_rd     = strobe_on && op_rd && !op_de;
        bus_wr     = strobe_on && !op_rd && !op_de;
        bus_dir    = active && op_rd && op_de;
        bus_en     = strobe_on && op_de;
        bus_be     = active && byte_hi;
        bus_doe    = active && !op_rd;
        bus_dout   = bus_doe ? (byte_hi ? wdata_q[15:8] : wdata_q[7:0]) : 8'h00;
    end

    // R6: separate strobes never both active
    a_r6_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    // R7: styles never mix
    a_r7_style_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en || bus_dir) |-> !(bus_rd || bus_wr));
    // R10: strobes and byte enable stay inside chip select
    a_r10_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr || bus_en || bus_be) |-> bus_cs);
    // R11: interrupt is a lone pulse right after an access
    a_r11_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(busy) && !busy));
    a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R12: a request while busy leaves the write data untouched
    a_r12_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (host_wr || host_rd)) |=> $stable(wdata_q));
endmodule

// File: tb/parbus_master_bench.sv
// Directed bench for parbus_master: every output is compared in every
// cycle of an access against a schedule computed from the settings.
module parbus_master_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_setup = '0;
    logic [3:0]  cfg_strobe = '0;
    logic [1:0]  cfg_hold = '0;
    logic        cfg_dir_en = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [1:0]  cfg_step = '0;
    logic [1:0]  cfg_irq = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        addr_ld = 1'b0;
    logic [AW-1:0] addr_val = '0;
    logic        busy, irq, bus_cs, bus_rd, bus_wr, bus_dir, bus_en, bus_be, bus_doe;
    logic [AW-1:0] bus_addr;
    logic [7:0]  bus_dout;
    logic [7:0]  bus_din = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [AW-1:0] mdl_addr = '0;

    always #2.5 clk = ~clk;

    parbus_master u_parbus_master (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cfg_dir_en(cfg_dir_en), .cfg_wide(cfg_wide), .cfg_step(cfg_step),
        .cfg_irq(cfg_irq), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .addr_ld(addr_ld), .addr_val(addr_val), .busy(busy), .irq(irq),
        .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dir(bus_dir),
        .bus_en(bus_en), .bus_be(bus_be), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pins();
        return {34'd0, busy, bus_cs, bus_rd, bus_wr, bus_dir, bus_en, bus_be,
                bus_doe, bus_addr, bus_dout};
    endfunction

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input logic [1:0] m);
        if (m == 2'b01) return a + 1'b1;
        if (m == 2'b10) return a - 1'b1;
        return a;
    endfunction

    // Run one access and compare every cycle with the modelled schedule.
    task automatic run_op(input string req, input bit rd, input bit wide, input bit de,
                          input int s, input int w, input int h,
                          input logic [1:0] step, input logic [1:0] irqm,
                          input logic [15:0] wd, input logic [7:0] lo,
                          input logic [7:0] hi, input bit poke);
        int n;
        bit stb, lst;
        logic [7:0] dexp;
        @(negedge clk);
        chk({req, " idle before"}, {63'd0, busy}, 64'd0);
        cfg_setup = 2'(s); cfg_strobe = 4'(w); cfg_hold = 2'(h);
        cfg_dir_en = de; cfg_wide = wide; cfg_step = step; cfg_irq = irqm;
        host_wdata = wd;
        if (rd) host_rd = 1'b1; else host_wr = 1'b1;
        n = (w == 0) ? 1 : (s + 1) + (w + 1) + (h + 1);
        for (int b = 0; b < (wide ? 2 : 1); b++) begin
            for (int t = 0; t < n; t++) begin
                @(negedge clk);
                host_wr = 1'b0; host_rd = 1'b0;
                if (poke && b == 0 && t == 1) begin
                    host_wr = 1'b1; host_rd = 1'b1; host_wdata = ~wd;
                end
                stb  = (w == 0) ? 1'b1 : (t >= s + 1 && t <= s + 1 + w);
                lst  = (w == 0) ? 1'b1 : (t == s + 1 + w);
                dexp = rd ? 8'h00 : (b == 1 ? wd[15:8] : wd[7:0]);
                chk(req, pins(), {34'd0, 1'b1, 1'b1, stb && rd && !de,
                    stb && !rd && !de, rd && de, stb && de, b == 1, !rd,
                    mdl_addr, dexp});
                bus_din = !stb ? 8'h33 : (!lst ? 8'hEE : (b == 1 ? hi : lo));
            end
            mdl_addr = next_addr(mdl_addr, step);
        end
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        chk({req, " end state"}, {48'd0, busy, bus_cs, irq, bus_addr},
            {48'd0, 1'b0, 1'b0, irqm == 2'b01, mdl_addr});
        if (rd) chk({req, " read data"}, {48'd0, host_rdata},
                    {48'd0, wide ? {hi, lo} : {8'h00, lo}});
        @(negedge clk);
        chk({req, " irq one cycle"}, {62'd0, irq, busy}, 64'd0);
    endtask

    task automatic load_addr(input logic [AW-1:0] v);
        @(negedge clk);
        addr_val = v; addr_ld = 1'b1;
        @(negedge clk);
        addr_ld = 1'b0;
        mdl_addr = v;
        chk("R14 address load", {50'd0, bus_addr}, {50'd0, v});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset pins", pins(), 64'd0);
        chk("R1 reset irq/rdata", {47'd0, irq, host_rdata}, 64'd0);
    endtask

    task automatic t_write_sep();
        load_addr(14'h0100);
        run_op("R2 R3 R4 R6 R10 R11 write sep", 0, 0, 0, 1, 2, 2, 2'b01, 2'b01,
               16'h00A5, 8'h00, 8'h00, 0);
    endtask

    task automatic t_read_de();
        run_op("R7 R13 R9 R11 read dir/en down", 1, 0, 1, 0, 3, 1, 2'b10, 2'b00,
               16'h0000, 8'h5C, 8'h00, 0);
    endtask

    task automatic t_fast();
        run_op("R5 single-cycle write", 0, 0, 0, 3, 0, 3, 2'b01, 2'b01,
               16'h0077, 8'h00, 8'h00, 0);
        run_op("R5 single-cycle read", 1, 0, 1, 3, 0, 3, 2'b00, 2'b00,
               16'h0000, 8'hC3, 8'h00, 0);
    endtask

    task automatic t_wide();
        run_op("R8 wide write", 0, 1, 0, 0, 1, 0, 2'b01, 2'b01,
               16'hBEEF, 8'h00, 8'h00, 0);
        run_op("R8 R13 wide read", 1, 1, 1, 2, 1, 1, 2'b10, 2'b01,
               16'h0000, 8'h12, 8'h9A, 0);
        run_op("R13 narrow read clears high", 1, 0, 0, 0, 1, 0, 2'b00, 2'b00,
               16'h0000, 8'h4D, 8'h00, 0);
    endtask

    task automatic t_long_strobe();
        run_op("R3 strobe 15", 0, 0, 1, 3, 15, 3, 2'b00, 2'b01,
               16'h0011, 8'h00, 8'h00, 0);
    endtask

    task automatic t_busy_ignore();
        run_op("R12 request while busy", 0, 0, 0, 0, 2, 0, 2'b01, 2'b01,
               16'h0F0F, 8'h00, 8'h00, 1);
    endtask

    task automatic t_wrap();
        load_addr(14'h3FFF);
        run_op("R9 wrap up", 0, 0, 0, 0, 1, 0, 2'b01, 2'b00,
               16'h0001, 8'h00, 8'h00, 0);
        run_op("R9 wrap down", 0, 0, 0, 0, 1, 0, 2'b10, 2'b00,
               16'h0002, 8'h00, 8'h00, 0);
        run_op("R9 mode 11 holds", 0, 1, 0, 0, 1, 0, 2'b11, 2'b00,
               16'h0304, 8'h00, 8'h00, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_sep();
        t_read_de();
        t_fast();
        t_wide();
        t_long_strobe();
        t_busy_ignore();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule